// File: doc/BRIEF.md
# eMMC Boot-Mode Sequencer

This block sequences a boot-data read from an eMMC device. It drives the command line and watches DAT0. A host controller starts a boot with a one-cycle request, and picks one of two entry methods. In the line-hold method the command line is driven low for the whole boot, and a stop request releases it. In the command method a 48-bit command frame with index 0 and argument 0xFFFFFFFA is shifted out first. A stop request then shifts out a second index-0 frame with argument 0x00000000, which closes the boot.

The sequencer can also check the device's boot acknowledge on DAT0, within a programmable number of cycles. When the check passes, or is turned off, it raises a data-enable output that tells the downstream data path to capture boot data. CRC checking of the data, data buffering and double-rate sampling belong to that data path and are not part of this block. The command line moves one bit per clock, so the block is clocked by the card clock.

Top module: `emmc_boot_seq`

## Requirements
- R1: After reset, `cmd_oe`, `boot_active`, `boot_done`, `ack_err` and `data_en` are all 0.
- R2: When `boot_go` is pulsed in idle with `alt_mode`=0, the next cycle shows `boot_active`=1, `cmd_oe`=1 and `cmd_o`=0. The line stays held low until a stop request.
- R3: In the line-hold method, a `soft_stop` pulse releases the line (`cmd_oe`=0) on the next cycle. In that same cycle `boot_done` is 1 for exactly one cycle and `boot_active` falls.
- R4: When `boot_go` is pulsed with `alt_mode`=1, the next 48 cycles carry `cmd_oe`=1 and a frame sent MSB first on `cmd_o`. The frame is: start bit 0, transmission bit 1, six-bit index 0, 32-bit argument 0xFFFFFFFA, CRC7 (polynomial x^7+x^3+1, zero seed, over the first 40 bits), and end bit 1. After the frame, `cmd_oe` returns to 0.
- R5: In the command method, a `soft_stop` pulse during boot sends one more 48-bit frame with index 0 and argument 0x00000000, whose CRC7 is 0x4A. The cycle after its last bit shows `boot_done`=1 and `boot_active`=0.
- R6: With `ack_chk`=0 at the start, `data_en` is 1 throughout the boot phase: after the start frame in the command method, or right after start in the line-hold method. It is 0 whenever `boot_active` is 0.
- R7: With `ack_chk`=1, `data_en` stays 0 until DAT0 shows a low start bit followed by the bits 0,1,0,1. After that it is 1 until the boot ends.
- R8: With `ack_chk`=1, if the four bits after the start bit differ from 0,1,0,1, then `ack_err` becomes 1 and `data_en` stays 0.
- R9: With `ack_chk`=1, if DAT0 stays high for more than `ack_tmo` boot-phase cycles, then `ack_err` becomes 1 and `data_en` stays 0.
- R10: A `boot_go` pulse while `boot_active`=1 has no effect. It does not send a new frame, it does not release the line, and it does not end the boot.
- R11: `ack_err` stays 1 after the boot ends. It is cleared only by the next accepted `boot_go`.
- R12: A `soft_stop` pulse while idle has no effect: `cmd_oe`, `boot_active` and `boot_done` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; one command bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_go | input | 1 | One-cycle boot start request |
| alt_mode | input | 1 | 0: line-hold method, 1: command method (sampled at start) |
| ack_chk | input | 1 | Enable boot acknowledge check (sampled at start) |
| ack_tmo | input | 16 | Acknowledge timeout in cycles |
| soft_stop | input | 1 | Boot stop request |
| dat0_i | input | 1 | DAT0 line from the device |
| cmd_o | output | 1 | Command line value |
| cmd_oe | output | 1 | Command line drive enable |
| boot_active | output | 1 | Boot sequence in progress |
| boot_done | output | 1 | One-cycle pulse when the boot ends |
| ack_err | output | 1 | Acknowledge missing or wrong (sticky) |
| data_en | output | 1 | Boot data may be captured by the data path |

## Verification
The hardest case to reach is the timing around the acknowledge. The check only arms once the start frame has ended, so a DAT0 pattern driven too early is silently missed. For the command method, the bench therefore waits until it has captured all 48 frame bits and seen `cmd_oe` fall, and only then drives the start bit and the four acknowledge bits on successive cycles. Wrong-pattern and timeout runs hold `ack_err` past the stop request. A later accepted start then has to clear it, which forces the bench to chain boots back to back.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;
  localparam int unsigned FRAME_LEN = 48;
  localparam int unsigned HDR_LEN   = 40;
  localparam int unsigned CRC_LEN   = 7;
  localparam int unsigned ARG_W     = 32;
  localparam int unsigned IDX_W     = 6;
  localparam logic [ARG_W-1:0] ARG_BOOT  = 32'hFFFF_FFFA;
  localparam logic [ARG_W-1:0] ARG_RESET = 32'h0000_0000;
  localparam logic [CRC_LEN-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_START,
    SQ_BOOT,
    SQ_TERM
  } seq_st_t;

  typedef enum logic [1:0] {
    AK_WAIT,
    AK_BITS,
    AK_OK,
    AK_ERR
  } ack_st_t;
endpackage

// File: rtl/boot_cmd_ser.sv
module boot_cmd_ser
  import emmc_boot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ARG_W-1:0] arg,
  output logic             bit_o,
  output logic             busy,
  output logic             last
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_HDR_END = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST    = CNT_W'(FRAME_LEN - 1);

  logic [HDR_LEN-1:0] hdr_q, hdr_d;
  logic [CRC_LEN-1:0] crc_q, crc_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               in_hdr, in_crc, fb;

  assign in_hdr = cnt_q < CNT_HDR_END;
  assign in_crc = !in_hdr && (cnt_q != CNT_LAST);
  assign fb     = hdr_q[HDR_LEN-1] ^ crc_q[CRC_LEN-1];
  assign last   = busy_q && (cnt_q == CNT_LAST);
  assign busy   = busy_q;

  always_comb begin
    if (in_hdr)      bit_o = hdr_q[HDR_LEN-1];
    else if (in_crc) bit_o = crc_q[CRC_LEN-1];
    else             bit_o = 1'b1;
  end

  always_comb begin
    hdr_d  = hdr_q;
    crc_d  = crc_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      hdr_d  = {1'b0, 1'b1, {IDX_W{1'b0}}, arg};
      crc_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (in_hdr) begin
        hdr_d = {hdr_q[HDR_LEN-2:0], 1'b0};
        crc_d = {crc_q[CRC_LEN-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end else if (in_crc) begin
        crc_d = {crc_q[CRC_LEN-2:0], 1'b0};
      end
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      crc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      hdr_q  <= hdr_d;
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/boot_ack_det.sv
module boot_ack_det
  import emmc_boot_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             dat0,
  input  logic [TMO_W-1:0] tmo,
  output logic             ok,
  output logic             err
);
  localparam int unsigned ACK_BITS = 4;
  localparam logic [ACK_BITS-1:0] ACK_PAT = 4'b0101;
  localparam logic [TMO_W-1:0] BIT_LAST = TMO_W'(ACK_BITS - 1);

  ack_st_t             st_q, st_d;
  logic [TMO_W-1:0]    cnt_q, cnt_d;
  logic [ACK_BITS-2:0] sh_q, sh_d;

  assign ok  = (st_q == AK_OK);
  assign err = (st_q == AK_ERR);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!arm) begin
      st_d  = AK_WAIT;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        AK_WAIT: begin
          if (!dat0) begin
            st_d  = AK_BITS;
            cnt_d = '0;
          end else if (cnt_q == tmo) begin
            st_d = AK_ERR;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        AK_BITS: begin
          sh_d  = {sh_q[ACK_BITS-3:0], dat0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == BIT_LAST)
            st_d = ({sh_q, dat0} == ACK_PAT) ? AK_OK : AK_ERR;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AK_WAIT;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
  import emmc_boot_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_go,
  input  logic             alt_mode,
  input  logic             ack_chk,
  input  logic [TMO_W-1:0] ack_tmo,
  input  logic             soft_stop,
  input  logic             dat0_i,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic             boot_active,
  output logic             boot_done,
  output logic             ack_err,
  output logic             data_en
);
  seq_st_t          st_q, st_d;
  logic             alt_q, alt_d, chk_q, chk_d;
  logic             done_q, done_d, err_q, err_d;
  logic             ser_load, ser_bit, ser_busy, ser_last;
  logic [ARG_W-1:0] ser_arg;
  logic             det_arm, det_ok, det_err;

  always_comb begin
    st_d     = st_q;
    alt_d    = alt_q;
    chk_d    = chk_q;
    done_d   = 1'b0;
    err_d    = err_q | det_err;
    ser_load = 1'b0;
    ser_arg  = ARG_BOOT;
    unique case (st_q)
      SQ_IDLE: if (boot_go) begin
        alt_d = alt_mode;
        chk_d = ack_chk;
        err_d = 1'b0;
        if (alt_mode) begin
          ser_load = 1'b1;
          st_d     = SQ_START;
        end else begin
          st_d = SQ_BOOT;
        end
      end
      SQ_START: if (ser_last) st_d = SQ_BOOT;
      SQ_BOOT: if (soft_stop) begin
        if (alt_q) begin
          ser_load = 1'b1;
          ser_arg  = ARG_RESET;
          st_d     = SQ_TERM;
        end else begin
          done_d = 1'b1;
          st_d   = SQ_IDLE;
        end
      end
      SQ_TERM: if (ser_last) begin
        done_d = 1'b1;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      alt_q  <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      alt_q  <= alt_d;
      chk_q  <= chk_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign det_arm = (st_q == SQ_BOOT) && chk_q;

  boot_cmd_ser u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ser_load),
    .arg   (ser_arg),
    .bit_o (ser_bit),
    .busy  (ser_busy),
    .last  (ser_last)
  );

  boot_ack_det #(.TMO_W(TMO_W)) u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (det_arm),
    .dat0  (dat0_i),
    .tmo   (ack_tmo),
    .ok    (det_ok),
    .err   (det_err)
  );

  always_comb begin
    cmd_oe = 1'b0;
    cmd_o  = 1'b1;
    if ((st_q == SQ_START || st_q == SQ_TERM) && ser_busy) begin
      cmd_oe = 1'b1;
      cmd_o  = ser_bit;
    end else if (st_q == SQ_BOOT && !alt_q) begin
      cmd_oe = 1'b1;
      cmd_o  = 1'b0;
    end
  end

  assign boot_active = (st_q != SQ_IDLE);
  assign boot_done   = done_q;
  assign ack_err     = err_q;
  assign data_en     = (st_q == SQ_BOOT) && (!chk_q || det_ok);
endmodule

// File: rtl/emmc_boot_seq_chk.sv
module emmc_boot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic boot_go,
  input logic alt_mode,
  input logic soft_stop,
  input logic cmd_o,
  input logic cmd_oe,
  input logic boot_active,
  input logic boot_done,
  input logic ack_err,
  input logic data_en
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |-> !cmd_oe && !data_en);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active && boot_go && !alt_mode |=> boot_active && cmd_oe && !cmd_o);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !boot_active && !cmd_oe);

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> !data_en);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err && !boot_go |=> ack_err);

  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active && soft_stop && !boot_go |=> !boot_active && !boot_done);
endmodule

bind emmc_boot_seq emmc_boot_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boot_go     (boot_go),
  .alt_mode    (alt_mode),
  .soft_stop   (soft_stop),
  .cmd_o       (cmd_o),
  .cmd_oe      (cmd_oe),
  .boot_active (boot_active),
  .boot_done   (boot_done),
  .ack_err     (ack_err),
  .data_en     (data_en)
);

// File: tb/sim_emmc_boot_seq.sv
module sim_emmc_boot_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  // vector: {alt, chk, use_pat, pat[4:0], exp_err, exp_data}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 5'b11111, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 5'b00101, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 5'b01011, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 5'b11111, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 5'b00101, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 5'b11111, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_go = 1'b0, alt_mode = 1'b0, ack_chk = 1'b0, soft_stop = 1'b0;
  logic dat0_i = 1'b1;
  logic [15:0] ack_tmo = 16'd8;
  logic cmd_o, cmd_oe, boot_active, boot_done, ack_err, data_en;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emmc_boot_seq u0 (
    .clk(clk), .rst_n(rst_n), .boot_go(boot_go), .alt_mode(alt_mode),
    .ack_chk(ack_chk), .ack_tmo(ack_tmo), .soft_stop(soft_stop),
    .dat0_i(dat0_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .boot_active(boot_active), .boot_done(boot_done),
    .ack_err(ack_err), .data_en(data_en)
  );

  function automatic logic [6:0] crc7(input logic [39:0] h);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = h[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] frame(input logic [31:0] a);
    logic [39:0] h = {2'b01, 6'd0, a};
    return {h, crc7(h), 1'b1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_go();
    boot_go = 1'b1;
    @(negedge clk);
    boot_go = 1'b0;
  endtask

  task automatic pulse_stop();
    soft_stop = 1'b1;
    @(negedge clk);
    soft_stop = 1'b0;
  endtask

  task automatic grab(output logic [47:0] f, output logic oe_ok);
    f = '0;
    oe_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      if (!cmd_oe) oe_ok = 1'b0;
      f = {f[46:0], cmd_o};
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] f;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {cmd_oe, boot_active, boot_done, ack_err, data_en}, 5'b0);

    // R5 known CRC of the stop frame
    chk("R5 crc", 64'(crc7({2'b01, 6'd0, 32'h0})), 64'h4A);

    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] e = VEC[v];
      alt_mode = e[9];
      ack_chk  = e[8];
      dat0_i   = 1'b1;
      pulse_go();
      alt_mode = 1'b0;
      ack_chk  = 1'b0;
      chk("R11 clear", 64'(ack_err), 64'h0);
      if (e[9]) begin
        grab(f, ok);
        chk("R4 frame", 64'(f), 64'(frame(32'hFFFF_FFFA)));
        chk("R4 oe", 64'(ok), 64'h1);
        chk("R4 release", 64'(cmd_oe), 64'h0);
      end else begin
        chk("R2", {cmd_oe, cmd_o, boot_active}, 3'b101);
      end
      if (e[7]) begin
        for (int b = 4; b >= 0; b--) begin
          dat0_i = e[2+b];
          @(negedge clk);
        end
        dat0_i = 1'b1;
        @(negedge clk);
      end else begin
        repeat (20) @(negedge clk);
      end
      if (e[8] && e[7] && !e[1]) chk("R7 data", 64'(data_en), 64'h1);
      else if (e[8] && e[7])     chk("R8 data", {ack_err, data_en}, 2'b10);
      else if (e[8])             chk("R9 timeout", {ack_err, data_en}, 2'b10);
      else                       chk("R6 data", 64'(data_en), 64'h1);
      if (!e[9]) chk("R2 hold", {cmd_oe, cmd_o}, 2'b10);
      pulse_stop();
      if (e[9]) begin
        chk("R5 busy", 64'(boot_active), 64'h1);
        grab(f, ok);
        chk("R5 frame", 64'(f), 64'(frame(32'h0)));
        chk("R5 end", {boot_done, boot_active, cmd_oe}, 3'b100);
      end else begin
        chk("R3 end", {boot_done, boot_active, cmd_oe}, 3'b100);
      end
      chk("R6 idle", 64'(data_en), 64'h0);
      @(negedge clk);
      chk("R3 pulse", 64'(boot_done), 64'h0);
      chk("R11 sticky", 64'(ack_err), 64'(e[1]));
      repeat (3) @(negedge clk);
    end

    // R12 stop while idle
    pulse_stop();
    chk("R12", {cmd_oe, boot_active, boot_done}, 3'b000);
    @(negedge clk);
    chk("R12 later", {cmd_oe, boot_active, boot_done}, 3'b000);

    // R10 go while active, line-hold method
    pulse_go();
    repeat (2) @(negedge clk);
    alt_mode = 1'b1;
    pulse_go();
    alt_mode = 1'b0;
    chk("R10 hold", {boot_active, cmd_oe, cmd_o}, 3'b110);
    repeat (4) @(negedge clk);
    chk("R10 hold later", {boot_active, cmd_oe, cmd_o}, 3'b110);
    pulse_stop();
    chk("R10 end", {boot_done, boot_active}, 2'b10);
    @(negedge clk);

    // R10 go while active, command method
    alt_mode = 1'b1;
    pulse_go();
    alt_mode = 1'b0;
    grab(f, ok);
    pulse_go();
    chk("R10 no frame", {boot_active, cmd_oe}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R10 no frame later", {boot_active, cmd_oe, data_en}, 3'b101);
    pulse_stop();
    grab(f, ok);
    chk("R10 stop frame", 64'(f), 64'(frame(32'h0)));
    chk("R10 finish", {boot_done, boot_active}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule